// File: doc/BRIEF.md
# Configuration Transaction Controller

This block lets a processor run one read or one write at a time against a remote configuration function. The processor sees three 32-bit registers on a simple register port: a data word, a control word and a status word. The control word packs the remote address into five fields: controller index, function, site, position and device. It also carries a direction bit and a start bit. Setting start while the block is idle sends the address, the direction and the data word to a downstream request/acknowledge port. The request is held there until the far side answers with done or error.

Software first clears status. For a write it then loads the data word. Finally it writes the control word with start set, and polls until the start bit reads back as zero. A completed read leaves the returned value in the data word. A transaction that gets no answer within `TIMEOUT_CYCLES` request cycles is abandoned and reported as an error.

Top module: `cfg_txn_ctrl`

## Requirements
- R1: After reset, the data, control and status words all read as zero and `reqValid` is low.
- R2: The data word sits at offset 0x0A0, the control word at 0x0A4 and the status word at 0x0A8. A write to the data word while idle reads back unchanged. Any other offset reads as zero.
- R3: A control write while idle with bit 31 (start) set raises `reqValid` in the next cycle. The request presents these fields of the written word:
  - bits 29:26 on `reqUnit`
  - bits 25:20 on `reqFunc`
  - bits 17:16 on `reqSite`
  - bits 15:12 on `reqSlot`
  - bits 11:0 on `reqDev`
  - bit 30 on `reqWrite` (1 = write, 0 = read)
  - the data word on `reqWData`
- R4: A control write while idle with bit 31 clear stores the fields but raises no request. Control bits 19:18 always read as zero.
- R5: Control bit 31 reads as 1 from the cycle after a launch until the cycle after the response is sampled, and reads as 0 otherwise.
- R6: While `reqValid` is high, it and all request fields stay stable until the cycle in which `rspDone` or `rspErr` is sampled high. `reqValid` is low in the following cycle.
- R7: Writes to the control word or the data word while a transaction is in flight are ignored. Fields, write data and the final data word are unaffected.
- R8: A `rspDone` response without `rspErr` sets status bit 0 (complete). For a read, it loads `rspRData` into the data word. For a write, the data word is kept.
- R9: A `rspErr` response sets status bit 1 (error), leaves bit 0 clear and leaves the data word unchanged.
- R10: If no response arrives, the request stays high for exactly `TIMEOUT_CYCLES` cycles. It then drops and status bit 1 is set.
- R11: Any write to the status word clears both status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 12 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| reqValid | output | 1 | Downstream request active |
| reqWrite | output | 1 | Direction: 1 = write, 0 = read |
| reqUnit | output | 4 | Controller index field |
| reqFunc | output | 6 | Function field |
| reqSite | output | 2 | Site field |
| reqSlot | output | 4 | Position field |
| reqDev | output | 12 | Device field |
| reqWData | output | 32 | Write data to the remote function |
| rspDone | input | 1 | Successful completion acknowledge |
| rspErr | input | 1 | Error acknowledge (takes priority over done) |
| rspRData | input | 32 | Read data returned with done |

## Verification
The assertions check these behaviours on every cycle:
- the request and its fields stay stable through a transaction, and the request drops right after an acknowledge;
- the start bit read back matches the request line;
- a done or error response lands in the status bits one cycle later;
- no request outlives the timeout window.

The bench's scenarios are needed for the rest:
- that writes made while busy leave no trace in the final data word;
- that a read captures the returned value while a write keeps its data;
- that a start-clear control write launches nothing;
- that the timeout lasts exactly the configured number of cycles.

The sweep covers field patterns, both directions, several acknowledge latencies and both response kinds.

// File: rtl/cfg_txn_pkg.sv
package cfg_txn_pkg;
  localparam int REG_AW = 12;
  localparam int REG_DW = 32;
  localparam logic [REG_AW-1:0] OFF_DATA = 12'h0A0;
  localparam logic [REG_AW-1:0] OFF_CTRL = 12'h0A4;
  localparam logic [REG_AW-1:0] OFF_STAT = 12'h0A8;

  localparam int START_BIT = 31;
  localparam int WRITE_BIT = 30;
  localparam int UNIT_LSB  = 26;
  localparam int UNIT_W    = 4;
  localparam int FUNC_LSB  = 20;
  localparam int FUNC_W    = 6;
  localparam int SITE_LSB  = 16;
  localparam int SITE_W    = 2;
  localparam int SLOT_LSB  = 12;
  localparam int SLOT_W    = 4;
  localparam int DEV_LSB   = 0;
  localparam int DEV_W     = 12;

  // bits that hold state in the control word (start is reported from the FSM)
  localparam logic [REG_DW-1:0] CTRL_KEEP = 32'h7FF3_FFFF;

  localparam int ST_DONE = 0;
  localparam int ST_ERR  = 1;

  typedef struct packed {
    logic loadData;
    logic loadCtrl;
    logic setDone;
    logic setErr;
    logic clrStat;
  } dpStrobe_t;
endpackage

// File: rtl/cfg_txn_ctl.sv
module cfg_txn_ctl
  import cfg_txn_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              wrStart,
  input  logic              rspDone,
  input  logic              rspErr,
  output logic              busy,
  output dpStrobe_t         stb
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] waitCnt;
  logic wrCtrl, wrData, wrStat;
  logic launch, ack, expire;

  always_comb begin
    wrCtrl = regWrEn && (regAddr == OFF_CTRL);
    wrData = regWrEn && (regAddr == OFF_DATA);
    wrStat = regWrEn && (regAddr == OFF_STAT);
    launch = wrCtrl && !busy && wrStart;
    ack    = busy && (rspDone || rspErr);
    expire = busy && !ack && (waitCnt == LAST_CNT);

    stb.loadCtrl = wrCtrl && !busy;
    stb.loadData = wrData && !busy;
    stb.setErr   = (ack && rspErr) || expire;
    stb.setDone  = ack && rspDone && !rspErr;
    stb.clrStat  = wrStat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      waitCnt <= '0;
    end else if (launch) begin
      busy    <= 1'b1;
      waitCnt <= '0;
    end else if (ack || expire) begin
      busy    <= 1'b0;
      waitCnt <= '0;
    end else if (busy) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_txn_dp.sv
module cfg_txn_dp
  import cfg_txn_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              busy,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWrData,
  output logic [REG_DW-1:0] regRdData,
  input  logic [REG_DW-1:0] rspRData,
  output logic              reqWrite,
  output logic [UNIT_W-1:0] reqUnit,
  output logic [FUNC_W-1:0] reqFunc,
  output logic [SITE_W-1:0] reqSite,
  output logic [SLOT_W-1:0] reqSlot,
  output logic [DEV_W-1:0]  reqDev,
  output logic [REG_DW-1:0] reqWData,
  output logic [1:0]        statusBits
);
  logic [REG_DW-1:0] dataReg;
  logic [REG_DW-1:0] ctrlReg;
  logic [1:0]        statReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
      ctrlReg <= '0;
      statReg <= '0;
    end else begin
      if (stb.loadData)
        dataReg <= regWrData;
      else if (stb.setDone && !ctrlReg[WRITE_BIT])
        dataReg <= rspRData;

      if (stb.loadCtrl)
        ctrlReg <= regWrData & CTRL_KEEP;

      if (stb.setErr)
        statReg[ST_ERR] <= 1'b1;
      else if (stb.setDone)
        statReg[ST_DONE] <= 1'b1;
      else if (stb.clrStat)
        statReg <= '0;
    end
  end

  always_comb begin
    reqWrite   = ctrlReg[WRITE_BIT];
    reqUnit    = ctrlReg[UNIT_LSB +: UNIT_W];
    reqFunc    = ctrlReg[FUNC_LSB +: FUNC_W];
    reqSite    = ctrlReg[SITE_LSB +: SITE_W];
    reqSlot    = ctrlReg[SLOT_LSB +: SLOT_W];
    reqDev     = ctrlReg[DEV_LSB +: DEV_W];
    reqWData   = dataReg;
    statusBits = statReg;
    unique case (regAddr)
      OFF_DATA: regRdData = dataReg;
      OFF_CTRL: regRdData = {busy, ctrlReg[REG_DW-2:0]};
      OFF_STAT: regRdData = {{(REG_DW-2){1'b0}}, statReg};
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/cfg_txn_ctrl.sv
module cfg_txn_ctrl
  import cfg_txn_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 4096
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [11:0] regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        reqValid,
  output logic        reqWrite,
  output logic [3:0]  reqUnit,
  output logic [5:0]  reqFunc,
  output logic [1:0]  reqSite,
  output logic [3:0]  reqSlot,
  output logic [11:0] reqDev,
  output logic [31:0] reqWData,
  input  logic        rspDone,
  input  logic        rspErr,
  input  logic [31:0] rspRData
);
  dpStrobe_t  stb;
  logic       busy;
  logic [1:0] statusBits;

  cfg_txn_ctl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .wrStart(regWrData[START_BIT]), .rspDone(rspDone), .rspErr(rspErr),
    .busy(busy), .stb(stb)
  );

  cfg_txn_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .rspRData(rspRData),
    .reqWrite(reqWrite), .reqUnit(reqUnit), .reqFunc(reqFunc),
    .reqSite(reqSite), .reqSlot(reqSlot), .reqDev(reqDev),
    .reqWData(reqWData), .statusBits(statusBits)
  );

  assign reqValid = busy;
endmodule

// File: rtl/cfg_txn_chk.sv
module cfg_txn_chk
  import cfg_txn_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 4096
) (
  input logic        clk,
  input logic        rstN,
  input logic [11:0] regAddr,
  input logic [31:0] regRdData,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [3:0]  reqUnit,
  input logic [5:0]  reqFunc,
  input logic [1:0]  reqSite,
  input logic [3:0]  reqSlot,
  input logic [11:0] reqDev,
  input logic [31:0] reqWData,
  input logic        rspDone,
  input logic        rspErr,
  input logic [1:0]  statusBits
);
  localparam int RUN_W = $clog2(TIMEOUT_CYCLES + 2) + 1;
  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN) runLen <= '0;
    else if (reqValid) runLen <= (runLen == {RUN_W{1'b1}}) ? runLen : runLen + 1'b1;
    else runLen <= '0;
  end

  // R6
  req_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && $past(reqValid) |->
      $stable({reqWrite, reqUnit, reqFunc, reqSite, reqSlot, reqDev, reqWData}));

  // R6
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && (rspDone || rspErr) |=> !reqValid);

  // R5
  start_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == OFF_CTRL) |-> (regRdData[START_BIT] == reqValid));

  // R8
  done_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && rspDone && !rspErr |=> statusBits[ST_DONE]);

  // R9
  err_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && rspErr |=> statusBits[ST_ERR] && !$rose(statusBits[ST_DONE]));

  // R10
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (runLen < RUN_W'(TIMEOUT_CYCLES)));
endmodule

bind cfg_txn_ctrl cfg_txn_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (.*);

// File: tb/cfg_txn_ctrl_bench.sv
`timescale 1ns/1ps
module cfg_txn_ctrl_bench;
  localparam int TMO = 16;
  localparam logic [11:0] A_DATA = 12'h0A0;
  localparam logic [11:0] A_CTRL = 12'h0A4;
  localparam logic [11:0] A_STAT = 12'h0A8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] regAddr = A_DATA;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic reqValid, reqWrite;
  logic [3:0] reqUnit, reqSlot;
  logic [5:0] reqFunc;
  logic [1:0] reqSite;
  logic [11:0] reqDev;
  logic [31:0] reqWData;
  logic rspDone = 1'b0, rspErr = 1'b0;
  logic [31:0] rspRData = '0;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cfg_txn_ctrl #(.TIMEOUT_CYCLES(TMO)) u_cfg_txn_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqUnit(reqUnit), .reqFunc(reqFunc),
    .reqSite(reqSite), .reqSlot(reqSlot), .reqDev(reqDev),
    .reqWData(reqWData), .rspDone(rspDone), .rspErr(rspErr),
    .rspRData(rspRData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [11:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  function automatic logic [31:0] mkWord(input int i, input bit wr);
    logic [3:0] u; logic [5:0] f; logic [1:0] s; logic [3:0] p; logic [11:0] d;
    u = 4'(i * 3 + 1);
    f = 6'(i * 11 + 5);
    s = 2'(i);
    p = 4'(15 - i);
    d = 12'(i * 517 + 9);
    return {1'b1, wr, u, f, 2'b00, s, p, d};
  endfunction

  function automatic logic [31:0] packedReq();
    return {1'b0, reqWrite, reqUnit, reqFunc, 2'b00, reqSite, reqSlot, reqDev};
  endfunction

  task automatic doTxn(input int i, input bit wr, input int lat, input bit isErr);
    logic [31:0] word, wdat, rdat, v, expData;
    word = mkWord(i, wr);
    wdat = 32'hA500_0000 + 32'(i * 32'h0001_0203) + 32'(lat);
    rdat = ~wdat ^ 32'h0F0F_0000;
    busWrite(A_STAT, 32'h0);
    busWrite(A_DATA, wdat);
    busWrite(A_CTRL, word);
    // R3: request visible the cycle after the control write
    chk("R3 reqValid after launch", {31'b0, reqValid}, 32'h1);
    chk("R3 decoded fields", packedReq(), word & 32'h7FF3_FFFF);
    chk("R3 write data", reqWData, wdat);
    readReg(A_CTRL, v);
    chk("R5 start reads 1 while busy", v, word);
    for (int k = 0; k < lat; k++) begin
      if (k == 0) busWrite(A_CTRL, word ^ 32'h3FFF_FFFF);
      else if (k == 1) busWrite(A_DATA, 32'hDEAD_0000 + 32'(k));
      else @(negedge clk);
      // R7: busy writes ignored; R6: request stable
      chk("R7 fields unchanged by busy writes", packedReq(), word & 32'h7FF3_FFFF);
      chk("R7 write data unchanged", reqWData, wdat);
      chk("R6 request held", {31'b0, reqValid}, 32'h1);
    end
    rspDone = !isErr; rspErr = isErr; rspRData = rdat;
    @(posedge clk);
    @(negedge clk);
    rspDone = 1'b0; rspErr = 1'b0; rspRData = 32'h0;
    chk("R6 request drops after ack", {31'b0, reqValid}, 32'h0);
    readReg(A_CTRL, v);
    chk("R5 start clears after ack", {31'b0, v[31]}, 32'h0);
    readReg(A_STAT, v);
    if (isErr) chk("R9 error status", v, 32'h2);
    else chk("R8 complete status", v, 32'h1);
    expData = (isErr || wr) ? wdat : rdat;
    readReg(A_DATA, v);
    if (isErr) chk("R9 data unchanged on error", v, expData);
    else chk("R8 data word after done", v, expData);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    readReg(A_DATA, v); chk("R1 data after reset", v, 32'h0);
    readReg(A_CTRL, v); chk("R1 ctrl after reset", v, 32'h0);
    readReg(A_STAT, v); chk("R1 status after reset", v, 32'h0);
    chk("R1 reqValid after reset", {31'b0, reqValid}, 32'h0);

    // R2
    busWrite(A_DATA, 32'h1234_5678);
    readReg(A_DATA, v); chk("R2 data readback", v, 32'h1234_5678);
    readReg(12'h0AC, v); chk("R2 unmapped offset", v, 32'h0);
    readReg(12'h000, v); chk("R2 unmapped offset zero", v, 32'h0);

    // R4
    busWrite(A_CTRL, 32'h7FFF_FFFF);
    chk("R4 no request without start", {31'b0, reqValid}, 32'h0);
    readReg(A_CTRL, v); chk("R4 stored fields, bits 19:18 zero", v, 32'h7FF3_FFFF);
    repeat (3) @(negedge clk);
    chk("R4 still idle", {31'b0, reqValid}, 32'h0);

    // sweep: R3 R5 R6 R7 R8 R9
    for (int i = 0; i < 8; i++)
      for (int w = 0; w < 2; w++)
        for (int lat = 0; lat < 4; lat++)
          doTxn(i, w[0], lat, ((i + lat + w) % 3) == 2);

    // R10 timeout
    busWrite(A_STAT, 32'h0);
    busWrite(A_DATA, 32'h0BAD_F00D);
    busWrite(A_CTRL, mkWord(5, 1'b0));
    cnt = 0;
    while (reqValid && cnt < 200) begin
      cnt++;
      @(negedge clk);
    end
    chk("R10 request length before timeout", 32'(cnt), 32'(TMO));
    readReg(A_STAT, v); chk("R10 error after timeout", v, 32'h2);
    readReg(A_DATA, v); chk("R10 data kept after timeout", v, 32'h0BAD_F00D);

    // R11
    busWrite(A_STAT, 32'hFFFF_FFFF);
    readReg(A_STAT, v); chk("R11 status cleared by write", v, 32'h0);
    doTxn(3, 1'b1, 1, 1'b0);
    busWrite(A_STAT, 32'h0000_0003);
    readReg(A_STAT, v); chk("R11 complete cleared", v, 32'h0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule